// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits between a 32-bit command word stream and a rasteriser. It splits the stream into packets. The opcode in bits 31:24 of the first word of each packet decides the packet's shape:

- a fixed number of parameter words,
- a polyline of open length that ends on a marker word,
- a single settings word that the block keeps in its own register bank,
- a three-word header that starts a pixel transfer.

Packets bound for the rasteriser leave one word per cycle with start and end flags. A packet that is only partly delivered stays open. Gaps in the input do not restart framing.

A transfer header is consumed internally. The block then pulses a start strobe that carries the position and size words and a direction flag. For a write transfer the input is held off until the transfer engine reports completion. This keeps payload pixels from being parsed as commands.

Top module: `cmd_framer`

## Requirements
- R1: Fixed-length packets are forwarded with start flag on their first word and end flag on word 1+N, where N is:
  - 2 for opcode 0x02;
  - 3 for 0x20-23, 6 for 0x24-27, 4 for 0x28-2B, 8 for 0x2C-2F;
  - 5 for 0x30-33, 8 for 0x34-37, 7 for 0x38-3B, 11 for 0x3C-3F;
  - 2 for 0x40-47, 3 for 0x50-57;
  - 2 for 0x60-63, 3 for 0x64-67, 1 for 0x68-6B;
  - 1 for 0x70-73, 2 for 0x74-77, 1 for 0x78-7B, 2 for 0x7C-7F;
  - 3 for the copy opcodes 0x80-9F.
- R2: Every opcode not named in R1, R3, R4, R5 or R6 forms a one-word packet. This includes 0x00, 0x6C-6F and 0xE8-FF. The word is forwarded with start and end flags both set.
- R3: Opcodes 0x48-4F open a flat polyline of at least 3 words. From the fourth word on, the first word whose value ANDed with 0xF000F000 equals 0x50005000 is forwarded with the end flag and closes the packet.
- R4: Opcodes 0x58-5F open a shaded polyline of at least 4 words. The marker of R3 is honoured only on the 5th, 7th, 9th and later odd-numbered words. A marker pattern on any other word is forwarded as plain data.
- R5: Opcodes 0xE0-E7 are not forwarded. The whole word is stored in settings slot i, where i is the opcode's low 3 bits. Slot i appears on env_regs bits [32*i+31:32*i] and resets to (0xE0+i)<<24.
- R6: Opcodes 0xA0-DF take a header plus two words, and none of the three is forwarded. In the cycle after the third word is accepted, xfer_start is high for exactly one cycle. At that point xfer_pos holds the second word, xfer_size holds the third, and xfer_read is 1 for opcodes 0xC0-DF.
- R7: After a write transfer start (opcodes 0xA0-BF), in_ready is low from the strobe cycle onward. It returns high in the cycle after xfer_done is sampled high. A read transfer never lowers in_ready.
- R8: A packet whose words have not all arrived gets no end flag. Framing continues with the next accepted word whatever the idle gap, and never restarts at that word.
- R9: Each forwarded word appears on out_data with out_valid one cycle after it is accepted. out_valid is low in every other cycle.
- R10: After reset, in_ready is high, out_valid and xfer_start are low, and all settings slots hold their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word present |
| in_data | input | 32 | Command word, opcode in bits 31:24 of a packet's first word |
| in_ready | output | 1 | Block can accept a word (low during a write transfer) |
| out_valid | output | 1 | Forwarded packet word valid |
| out_data | output | 32 | Forwarded packet word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| env_regs | output | 256 | Eight settings slots, slot i at bits [32*i+31:32*i] |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_pos | output | 32 | Position word of the transfer header |
| xfer_size | output | 32 | Size word of the transfer header |
| xfer_done | input | 1 | Transfer engine finished, releases the input stall |

## Verification
Most state errors in this block show up at the ports within one packet.

- A wrong word index or a misclassified opcode puts the end flag on the wrong word in the cycle after that word is accepted.
- The same fault makes the next packet's first word arrive without its start flag, so the framing loss is visible at the next packet boundary.
- A wrong polyline parity shows as a marker that is honoured or ignored one word off.
- A stuck transfer-busy state shows as in_ready held low after xfer_done, or as header words leaking onto the output.

The vectors place marker patterns on both honoured and ignored word slots for this reason. The directed tests leave gaps inside packets.

// File: rtl/cmd_framer_pkg.sv
package cmd_framer_pkg;

    localparam int EXTRA_W = 4;

    typedef enum logic [2:0] {
        K_FIXED       = 3'd0,
        K_POLY_FLAT   = 3'd1,
        K_POLY_SHADED = 3'd2,
        K_XFER        = 3'd3,
        K_ENV         = 3'd4
    } pkt_kind_e;

    typedef struct packed {
        pkt_kind_e            kind;
        logic [EXTRA_W-1:0]   extra;
        logic                 is_read;
    } op_info_t;

endpackage

// File: rtl/cmd_framer_decode.sv
module cmd_framer_decode
    import cmd_framer_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);

    always_comb begin
        info.kind    = K_FIXED;
        info.extra   = '0;
        info.is_read = 1'b0;
        unique case (opcode[7:5])
            3'b000: info.extra = (opcode == 8'h02) ? EXTRA_W'(2) : '0;
            3'b001: begin
                unique case (opcode[4:2])
                    3'd0: info.extra = EXTRA_W'(3);
                    3'd1: info.extra = EXTRA_W'(6);
                    3'd2: info.extra = EXTRA_W'(4);
                    3'd3: info.extra = EXTRA_W'(8);
                    3'd4: info.extra = EXTRA_W'(5);
                    3'd5: info.extra = EXTRA_W'(8);
                    3'd6: info.extra = EXTRA_W'(7);
                    default: info.extra = EXTRA_W'(11);
                endcase
            end
            3'b010: begin
                unique case (opcode[4:3])
                    2'd0: info.extra = EXTRA_W'(2);
                    2'd1: info.kind  = K_POLY_FLAT;
                    2'd2: info.extra = EXTRA_W'(3);
                    default: info.kind = K_POLY_SHADED;
                endcase
            end
            3'b011: begin
                unique case (opcode[4:2])
                    3'd0: info.extra = EXTRA_W'(2);
                    3'd1: info.extra = EXTRA_W'(3);
                    3'd2: info.extra = EXTRA_W'(1);
                    3'd3: info.extra = '0;
                    3'd4: info.extra = EXTRA_W'(1);
                    3'd5: info.extra = EXTRA_W'(2);
                    3'd6: info.extra = EXTRA_W'(1);
                    default: info.extra = EXTRA_W'(2);
                endcase
            end
            3'b100: info.extra = EXTRA_W'(3);
            3'b101: info.kind  = K_XFER;
            3'b110: begin
                info.kind    = K_XFER;
                info.is_read = 1'b1;
            end
            default: begin
                if (opcode[4:3] == 2'b00) info.kind = K_ENV;
            end
        endcase
    end

endmodule

// File: rtl/cmd_framer_env.sv
module cmd_framer_env #(
    parameter int ENV_N  = 8,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(ENV_N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          idx,
    input  logic [WORD_W-1:0]         wdata,
    output logic [ENV_N*WORD_W-1:0]   regs_flat
);

    for (genvar i = 0; i < ENV_N; i++) begin : g_slot
        localparam logic [WORD_W-1:0] RST_VAL = {8'(8'hE0 + i), {(WORD_W-8){1'b0}}};
        logic [WORD_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (we && (idx == IDX_W'(i))) slot_d = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= RST_VAL;
            else        slot_q <= slot_d;
        end

        assign regs_flat[i*WORD_W +: WORD_W] = slot_q;
    end

endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
    import cmd_framer_pkg::*;
#(
    parameter int          WORD_W    = 32,
    parameter int          ENV_N     = 8,
    parameter logic [31:0] MARK_MASK = 32'hF000_F000,
    parameter logic [31:0] MARK_VAL  = 32'h5000_5000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [WORD_W-1:0]       in_data,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic [WORD_W-1:0]       out_data,
    output logic                    out_sop,
    output logic                    out_eop,
    output logic [ENV_N*WORD_W-1:0] env_regs,
    output logic                    xfer_start,
    output logic                    xfer_read,
    output logic [WORD_W-1:0]       xfer_pos,
    output logic [WORD_W-1:0]       xfer_size,
    input  logic                    xfer_done
);

    localparam int ENV_IDX_W = $clog2(ENV_N);
    localparam int OP_LSB    = WORD_W - 8;
    localparam logic [EXTRA_W-1:0] FLAT_MIN   = EXTRA_W'(3);
    localparam logic [EXTRA_W-1:0] SHADED_MIN = EXTRA_W'(4);
    localparam logic [EXTRA_W-1:0] SHADED_TOP = EXTRA_W'(5);

    typedef struct packed {
        logic               in_pkt;
        logic               busy;
        pkt_kind_e          kind;
        logic [EXTRA_W-1:0] extra;
        logic [EXTRA_W-1:0] idx;
        logic               rd;
        logic               o_valid;
        logic               o_sop;
        logic               o_eop;
        logic [WORD_W-1:0]  o_data;
        logic               x_start;
        logic               x_read;
        logic [WORD_W-1:0]  x_pos;
        logic [WORD_W-1:0]  x_size;
    } state_t;

    state_t q, d;
    op_info_t info;
    logic accept, is_marker, flat_end, shaded_end, fixed_end;
    logic env_we;
    logic [ENV_IDX_W-1:0] env_idx;

    cmd_framer_decode u_decode (
        .opcode (in_data[OP_LSB +: 8]),
        .info   (info)
    );

    cmd_framer_env #(.ENV_N(ENV_N), .WORD_W(WORD_W)) u_env (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (env_we),
        .idx       (env_idx),
        .wdata     (in_data),
        .regs_flat (env_regs)
    );

    assign in_ready   = !q.busy;
    assign accept     = in_valid && in_ready;
    assign is_marker  = (in_data[31:0] & MARK_MASK) == MARK_VAL;
    assign fixed_end  = (q.idx == q.extra);
    assign flat_end   = (q.idx >= FLAT_MIN) && is_marker;
    assign shaded_end = (q.idx >= SHADED_MIN) && !q.idx[0] && is_marker;
    assign env_idx    = in_data[OP_LSB +: ENV_IDX_W];

    always_comb begin
        d         = q;
        d.o_valid = 1'b0;
        d.o_sop   = 1'b0;
        d.o_eop   = 1'b0;
        d.x_start = 1'b0;
        env_we    = 1'b0;
        if (q.busy && xfer_done) d.busy = 1'b0;
        if (accept) begin
            d.o_data = in_data;
            if (!q.in_pkt) begin
                d.kind  = info.kind;
                d.extra = info.extra;
                d.rd    = info.is_read;
                d.idx   = EXTRA_W'(1);
                unique case (info.kind)
                    K_ENV:  env_we   = 1'b1;
                    K_XFER: d.in_pkt = 1'b1;
                    K_FIXED: begin
                        d.o_valid = 1'b1;
                        d.o_sop   = 1'b1;
                        d.o_eop   = (info.extra == '0);
                        d.in_pkt  = (info.extra != '0);
                    end
                    default: begin
                        d.o_valid = 1'b1;
                        d.o_sop   = 1'b1;
                        d.in_pkt  = 1'b1;
                    end
                endcase
            end else begin
                d.idx = q.idx + 1'b1;
                unique case (q.kind)
                    K_FIXED: begin
                        d.o_valid = 1'b1;
                        d.o_eop   = fixed_end;
                        d.in_pkt  = !fixed_end;
                    end
                    K_POLY_FLAT: begin
                        d.o_valid = 1'b1;
                        d.o_eop   = flat_end;
                        d.in_pkt  = !flat_end;
                        if (q.idx == FLAT_MIN) d.idx = FLAT_MIN;
                    end
                    K_POLY_SHADED: begin
                        d.o_valid = 1'b1;
                        d.o_eop   = shaded_end;
                        d.in_pkt  = !shaded_end;
                        if (q.idx == SHADED_TOP) d.idx = SHADED_MIN;
                    end
                    K_XFER: begin
                        if (q.idx == EXTRA_W'(1)) begin
                            d.x_pos = in_data;
                        end else begin
                            d.x_size  = in_data;
                            d.x_start = 1'b1;
                            d.x_read  = q.rd;
                            d.in_pkt  = 1'b0;
                            d.busy    = !q.rd;
                        end
                    end
                    default: d.in_pkt = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid  = q.o_valid;
    assign out_data   = q.o_data;
    assign out_sop    = q.o_sop;
    assign out_eop    = q.o_eop;
    assign xfer_start = q.x_start;
    assign xfer_read  = q.x_read;
    assign xfer_pos   = q.x_pos;
    assign xfer_size  = q.x_size;

    // Independent packet-open tracker used only by the checks below.
    logic chk_open_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         chk_open_q <= 1'b0;
        else if (out_valid) chk_open_q <= !out_eop;
    end

    // R1
    sop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sop == !chk_open_q));

    // R6
    xfer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R7
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !xfer_read) |-> !in_ready);

    // R9
    out_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready));

endmodule

// File: tb/tb_cmd_framer.sv
`timescale 1ns/1ps
module tb_cmd_framer;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [31:0]  in_data;
    logic         in_ready;
    logic         out_valid, out_sop, out_eop;
    logic [31:0]  out_data;
    logic [255:0] env_regs;
    logic         xfer_start, xfer_read, xfer_done;
    logic [31:0]  xfer_pos, xfer_size;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    cmd_framer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .env_regs(env_regs),
        .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_pos(xfer_pos),
        .xfer_size(xfer_size), .xfer_done(xfer_done)
    );

    // {word, expected valid, sop, eop}
    localparam int NVEC = 45;
    localparam logic [34:0] VEC [NVEC] = '{
        {32'h0000_0000, 3'b111},                                              // R2
        {32'h02AA_BBCC, 3'b110}, {32'h0010_0010, 3'b100}, {32'h0020_0020, 3'b101}, // R1
        {32'h20FF_0000, 3'b110}, {32'h0001_0001, 3'b100}, {32'h0002_0002, 3'b100},
        {32'h0003_0003, 3'b101},                                              // R1
        {32'h4812_3456, 3'b110}, {32'h0011_0011, 3'b100}, {32'h5000_5000, 3'b100},
        {32'h0123_0456, 3'b100}, {32'h5555_5555, 3'b101},                     // R3
        {32'h58AB_CDEF, 3'b110}, {32'h5000_5000, 3'b100}, {32'h0022_0022, 3'b100},
        {32'h5000_5000, 3'b100}, {32'h1234_5678, 3'b100}, {32'h5ABC_5DEF, 3'b100},
        {32'h5000_5000, 3'b101},                                              // R4
        {32'hE101_2345, 3'b000},                                              // R5
        {32'h8000_0000, 3'b110}, {32'h0000_0000, 3'b100}, {32'h0040_0040, 3'b100},
        {32'h0010_0010, 3'b101},                                              // R1
        {32'hFF00_0000, 3'b111}, {32'hE800_0000, 3'b111},                     // R2
        {32'h3C00_0000, 3'b110}, {32'h0000_0001, 3'b100}, {32'h0000_0002, 3'b100},
        {32'h0000_0003, 3'b100}, {32'h0000_0004, 3'b100}, {32'h0000_0005, 3'b100},
        {32'h0000_0006, 3'b100}, {32'h0000_0007, 3'b100}, {32'h0000_0008, 3'b100},
        {32'h0000_0009, 3'b100}, {32'h0000_000A, 3'b100}, {32'h0000_000B, 3'b101},
        {32'h6400_0000, 3'b110}, {32'h0000_0001, 3'b100}, {32'h0000_0002, 3'b100},
        {32'h0000_0003, 3'b101},                                              // R1
        {32'h6800_0000, 3'b110}, {32'h0000_0000, 3'b101}                      // R1
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; xfer_done = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(in_ready == 1'b1, "R10", "in_ready", {31'd0, in_ready}, 32'd1);
        chk(out_valid == 1'b0, "R10", "out_valid", {31'd0, out_valid}, 32'd0);
        chk(xfer_start == 1'b0, "R10", "xfer_start", {31'd0, xfer_start}, 32'd0);
        for (int i = 0; i < 8; i++)
            chk(env_regs[i*32 +: 32] == {8'(8'hE0 + i), 24'd0}, "R10", "env slot",
                env_regs[i*32 +: 32], {8'(8'hE0 + i), 24'd0});

        // R9 vector walk: each word shows one cycle after acceptance
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] w;
            logic [2:0]  e;
            w = VEC[i][34:3];
            e = VEC[i][2:0];
            push(w);
            chk({out_valid, out_sop, out_eop} == e && (!e[2] || out_data == w),
                "R9", $sformatf("vector %0d flags/data", i),
                {out_data[27:0], 1'b0, out_valid, out_sop, out_eop}, {w[27:0], 1'b0, e});
        end

        // R5 settings slot captured, others untouched
        chk(env_regs[32 +: 32] == 32'hE101_2345, "R5", "slot1", env_regs[32 +: 32], 32'hE101_2345);
        chk(env_regs[0 +: 32] == 32'hE000_0000, "R5", "slot0", env_regs[0 +: 32], 32'hE000_0000);
        chk(env_regs[224 +: 32] == 32'hE700_0000, "R5", "slot7", env_regs[224 +: 32], 32'hE700_0000);

        // R6 read transfer
        push(32'hC000_0000);
        chk(!out_valid, "R6", "hdr not forwarded", {31'd0, out_valid}, 32'd0);
        push(32'h0008_0010);
        chk(!xfer_start && !out_valid, "R6", "no early strobe", {31'd0, xfer_start}, 32'd0);
        push(32'h0002_0004);
        chk(xfer_start && xfer_read, "R6", "read strobe", {30'd0, xfer_start, xfer_read}, 32'd3);
        chk(xfer_pos == 32'h0008_0010, "R6", "pos", xfer_pos, 32'h0008_0010);
        chk(xfer_size == 32'h0002_0004, "R6", "size", xfer_size, 32'h0002_0004);
        chk(in_ready, "R7", "read keeps ready", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        chk(!xfer_start, "R6", "strobe one cycle", {31'd0, xfer_start}, 32'd0);

        // R7 write transfer stalls input until done
        push(32'hA000_0000);
        push(32'h0030_0040);
        push(32'h0001_0002);
        chk(xfer_start && !xfer_read, "R6", "write strobe", {30'd0, xfer_start, xfer_read}, 32'd2);
        chk(!in_ready, "R7", "stall at strobe", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b1; in_data = 32'h6800_0000;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!in_ready && !out_valid, "R7", "stalled word held",
                {30'd0, in_ready, out_valid}, 32'd0);
        end
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk(in_ready, "R7", "ready after done", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_sop && !out_eop && out_data == 32'h6800_0000, "R7",
            "held word accepted", {out_data[27:0], 1'b0, out_valid, out_sop, out_eop},
            {28'h8000000, 4'b0110});
        push(32'h0000_0000);
        chk(out_valid && out_eop, "R1", "0x68 close", {30'd0, out_valid, out_eop}, 32'd3);

        // R8 incomplete packet across an idle gap
        push(32'h2800_0000);
        push(32'h0000_0011);
        begin
            bit seen;
            seen = 1'b0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (out_valid) seen = 1'b1;
            end
            chk(!seen, "R8", "idle gap silent", {31'd0, seen}, 32'd0);
        end
        push(32'h0000_0022);
        chk(out_valid && !out_sop && !out_eop, "R8", "resume mid packet",
            {29'd0, out_valid, out_sop, out_eop}, 32'd4);
        push(32'h0000_0033);
        chk(out_valid && !out_eop, "R8", "still open", {30'd0, out_valid, out_eop}, 32'd2);
        push(32'h0000_0044);
        chk(out_valid && out_eop && !out_sop, "R8", "closes on 5th word",
            {29'd0, out_valid, out_sop, out_eop}, 32'd5);
        @(negedge clk);
        chk(!out_valid, "R9", "idle after packet", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule